// File: doc/BRIEF.md
# Tag CAM with LRU Reporting

This block is a small fully associative tag store. It has sixteen entries. Each entry holds a 32-bit tag, a valid flag and a 4-bit state field. Software writes the state field, and the hardware hands it back without ever interpreting it. A lookup presents a 32-bit key, and the key is compared against every entry in the same cycle. One clock later a packed result word appears together with a strobe.

On a hit, the result names the matching entry and returns that entry's state bits. On a miss, the result names the entry that was used least recently, so software can take it directly as the victim for its next write. Both a lookup hit and a write count as a use of an entry.

A clear command invalidates the whole array in one cycle. Clearing does not change the recency order.

Top module: `tag_cam`

## Requirements
- R1: After reset, `res_vld` is low and every entry is invalid. The recency order runs from entry 0 as most recent to entry 15 as least recent, so the first lookup after reset misses with index 15.
- R2: A lookup requested in cycle N gives `res_vld` high in cycle N+1 only. The result word is packed as bit 8 = hit, bits 7:4 = state, bits 3:0 = index.
- R3: On a hit, the index is the number of the matching valid entry. The state field is exactly the 4 bits last written to that entry.
- R4: On a miss, bit 8 is 0, the state field is 0 and the index is the least recently used entry.
- R5: A lookup hit or a write moves the touched entry to most recent, and every entry that was ahead of it moves back by one place. A miss leaves the order unchanged.
- R6: When several valid entries hold the key, the lowest-numbered one is reported.
- R7: A clear makes every entry invalid, and an invalid entry never hits. The recency order is unchanged by a clear.
- R8: A lookup sees the contents and the order as they were before any write or clear issued in the same cycle. A hit issued together with a write touches the hit entry first and the written entry second. A write issued together with a clear leaves the written entry valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | 4 | Entry number to write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State bits to store |
| lk_en | input | 1 | Request a lookup |
| lk_key | input | 32 | Key to search for |
| clr | input | 1 | Invalidate all entries |
| res_vld | output | 1 | Result strobe, one cycle after the lookup |
| res_word | output | 9 | {hit, state[3:0], index[3:0]} |

## Verification
A lookup, a write and a clear can all land in the same cycle. The write can target the very entry the lookup is about to hit, or the entry it reports as the victim. Directed cycles issue these pairs together: a lookup with a write to the same entry, a lookup with a write to a different entry, a lookup with a clear, and a write with a clear. A long pseudo-random run over a small key set then makes such coincidences frequent. Each result is judged against a behavioural model that applies the lookup, then the touches, then the clear and the write, in the order R8 defines.

// File: rtl/tag_cam_pkg.sv
package tag_cam_pkg;
   localparam int CAM_ENTRIES = 16;
   localparam int CAM_TAG_W   = 32;
   localparam int CAM_ST_W    = 4;
endpackage

// File: rtl/tag_cam_store.sv
module tag_cam_store #(
   parameter int ENTRIES = tag_cam_pkg::CAM_ENTRIES,
   parameter int TAG_W   = tag_cam_pkg::CAM_TAG_W,
   parameter int ST_W    = tag_cam_pkg::CAM_ST_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [IDX_W-1:0]                 wr_idx,
   input  logic [TAG_W-1:0]                 wr_tag,
   input  logic [ST_W-1:0]                  wr_state,
   input  logic                             clr,
   output logic [ENTRIES-1:0][TAG_W-1:0]    tags,
   output logic [ENTRIES-1:0][ST_W-1:0]     states,
   output logic [ENTRIES-1:0]               valid
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid  <= '0;
         tags   <= '0;
         states <= '0;
      end else begin
         if (clr)
            valid <= '0;
         if (wr_en) begin
            valid[wr_idx]  <= 1'b1;
            tags[wr_idx]   <= wr_tag;
            states[wr_idx] <= wr_state;
         end
      end
   end

   // R7
   clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !wr_en |=> valid == '0);

endmodule

// File: rtl/tag_cam_match.sv
module tag_cam_match #(
   parameter int ENTRIES = tag_cam_pkg::CAM_ENTRIES,
   parameter int TAG_W   = tag_cam_pkg::CAM_TAG_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
   input  logic [ENTRIES-1:0]            valid,
   input  logic [TAG_W-1:0]              key,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);

   logic [ENTRIES-1:0] match_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_vec[e] = valid[e] && (tags[e] == key);
   end

   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match_vec[e]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(e);
         end
      end
   end

   // R6
   lowest_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> match_vec[hit_idx] &&
              ((match_vec & ((ENTRIES'(1) << hit_idx) - ENTRIES'(1))) == '0));

   // R7
   no_false_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid == '0) |-> !hit);

endmodule

// File: rtl/tag_cam_lru.sv
module tag_cam_lru #(
   parameter int ENTRIES = tag_cam_pkg::CAM_ENTRIES,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             first_en,
   input  logic [IDX_W-1:0] first_idx,
   input  logic             second_en,
   input  logic [IDX_W-1:0] second_idx,
   output logic [IDX_W-1:0] lru_idx
);

   typedef logic [ENTRIES-1:0][IDX_W-1:0] order_t;

   order_t order_q, order_d;
   logic [ENTRIES-1:0] present;

   function automatic order_t promote(order_t o, logic [IDX_W-1:0] x);
      order_t r;
      logic   seen;
      seen = 1'b0;
      r[0] = x;
      for (int p = 1; p < ENTRIES; p++) begin
         if (!seen && o[p-1] == x)
            seen = 1'b1;
         r[p] = seen ? o[p] : o[p-1];
      end
      return r;
   endfunction

   always_comb begin
      order_d = order_q;
      if (first_en)
         order_d = promote(order_d, first_idx);
      if (second_en)
         order_d = promote(order_d, second_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < ENTRIES; p++)
            order_q[p] <= IDX_W'(p);
      end else begin
         order_q <= order_d;
      end
   end

   assign lru_idx = order_q[ENTRIES-1];

   always_comb begin
      present = '0;
      for (int p = 0; p < ENTRIES; p++)
         present[order_q[p]] = 1'b1;
   end

   // R5
   order_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      &present);

   // R5
   miss_keeps_lru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !first_en && !second_en |=> $stable(lru_idx));

endmodule

// File: rtl/tag_cam.sv
module tag_cam #(
   parameter int ENTRIES = tag_cam_pkg::CAM_ENTRIES,
   parameter int TAG_W   = tag_cam_pkg::CAM_TAG_W,
   parameter int ST_W    = tag_cam_pkg::CAM_ST_W,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int RES_W  = 1 + ST_W + IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [ST_W-1:0]  wr_state,
   input  logic             lk_en,
   input  logic [TAG_W-1:0] lk_key,
   input  logic             clr,
   output logic             res_vld,
   output logic [RES_W-1:0] res_word
);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("tag_cam: ENTRIES must be a power of two, at least 2");
   end
   if (TAG_W < 1 || ST_W < 1) begin : g_bad_width
      $error("tag_cam: TAG_W and ST_W must be positive");
   end

   logic [ENTRIES-1:0][TAG_W-1:0] tags;
   logic [ENTRIES-1:0][ST_W-1:0]  states;
   logic [ENTRIES-1:0]            valid;
   logic                          hit;
   logic [IDX_W-1:0]              hit_idx;
   logic [IDX_W-1:0]              lru_idx;

   tag_cam_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ST_W(ST_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_tag(wr_tag), .wr_state(wr_state), .clr(clr),
      .tags(tags), .states(states), .valid(valid)
   );

   tag_cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
      .clk(clk), .rst_n(rst_n), .tags(tags), .valid(valid), .key(lk_key),
      .hit(hit), .hit_idx(hit_idx)
   );

   tag_cam_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n),
      .first_en(lk_en && hit), .first_idx(hit_idx),
      .second_en(wr_en), .second_idx(wr_idx),
      .lru_idx(lru_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_word <= '0;
      end else begin
         res_vld <= lk_en;
         if (lk_en)
            res_word <= hit ? {1'b1, states[hit_idx], hit_idx}
                            : {1'b0, {ST_W{1'b0}}, lru_idx};
      end
   end

   // R4
   miss_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en && !hit |=> !res_word[RES_W-1] &&
                        res_word[IDX_W-1:0] == $past(lru_idx) &&
                        res_word[RES_W-2:IDX_W] == '0);

   // R3
   hit_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en && hit |=> res_word[RES_W-1] &&
                       res_word[RES_W-2:IDX_W] == $past(states[hit_idx]));

endmodule

// File: tb/tag_cam_test.sv
`timescale 1ns/1ps
module tag_cam_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_tag = '0;
   logic [3:0]  wr_state = '0;
   logic        lk_en = 1'b0;
   logic [31:0] lk_key = '0;
   logic        clr = 1'b0;
   logic        res_vld;
   logic [8:0]  res_word;

   int total = 0;
   int bad = 0;
   bit done = 0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   tag_cam uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_tag(wr_tag), .wr_state(wr_state), .lk_en(lk_en), .lk_key(lk_key),
      .clr(clr), .res_vld(res_vld), .res_word(res_word)
   );

   // behavioural reference
   logic [31:0] m_tag [16];
   logic [3:0]  m_st  [16];
   bit          m_val [16];
   int          m_ord [$];
   bit          exp_vld;
   logic [8:0]  exp_word;

   function automatic void m_touch(int x);
      foreach (m_ord[i]) begin
         if (m_ord[i] == x) begin
            m_ord.delete(i);
            break;
         end
      end
      m_ord.push_front(x);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ord.delete();
         for (int i = 0; i < 16; i++) begin
            m_ord.push_back(i);
            m_val[i] = 0;
            m_tag[i] = '0;
            m_st[i]  = '0;
         end
         exp_vld  = 0;
         exp_word = '0;
      end else begin
         int h;
         h = -1;
         if (lk_en) begin
            for (int i = 15; i >= 0; i--)
               if (m_val[i] && m_tag[i] == lk_key) h = i;
            if (h >= 0) exp_word = {1'b1, m_st[h], 4'(h)};
            else        exp_word = {1'b0, 4'h0, 4'(m_ord[15])};
         end
         exp_vld = lk_en;
         if (h >= 0) m_touch(h);
         if (wr_en) m_touch(int'(wr_idx));
         if (clr)
            for (int i = 0; i < 16; i++) m_val[i] = 0;
         if (wr_en) begin
            m_val[wr_idx] = 1;
            m_tag[wr_idx] = wr_tag;
            m_st[wr_idx]  = wr_state;
         end
      end
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n || phase == "R1") begin
         total++;
         if (res_vld !== exp_vld) begin
            bad++;
            $display("FAIL %s/R2 res_vld act=%0b exp=%0b t=%0t", phase, res_vld, exp_vld, $time);
         end
         if (exp_vld) begin
            total++;
            if (res_word !== exp_word) begin
               bad++;
               $display("FAIL %s/%s res_word act=%h exp=%h t=%0t", phase,
                        exp_word[8] ? "R3" : "R4", res_word, exp_word, $time);
            end
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      wr_en = 0; lk_en = 0; clr = 0;
   endtask

   task automatic wr(int idx, logic [31:0] tag, logic [3:0] st);
      wr_en = 1; wr_idx = 4'(idx); wr_tag = tag; wr_state = st;
   endtask

   task automatic lk(logic [31:0] key);
      lk_en = 1; lk_key = key;
   endtask

   // directed check of a specific lookup result, one cycle later
   task automatic expect_look(logic [31:0] key, logic [8:0] want, string tag);
      lk(key);
      tick();
      total++;
      if (res_vld !== 1'b1 || res_word !== want) begin
         bad++;
         $display("FAIL %s directed act=%h exp=%h", tag, res_word, want);
      end
   endtask

   initial begin
      int seed;
      // R1: reset state
      repeat (3) @(negedge clk);
      total++;
      if (res_vld !== 1'b0) begin
         bad++;
         $display("FAIL R1 res_vld in reset act=%0b exp=0", res_vld);
      end
      rst_n = 1;
      tick();
      expect_look(32'h5, 9'h00F, "R1");

      // R3: fill and hit
      phase = "R3";
      for (int i = 0; i < 16; i++) begin
         wr(i, 32'h1000 + i * 7, 4'(i ^ 5));
         tick();
      end
      expect_look(32'h1000 + 3 * 7, {1'b1, 4'(3 ^ 5), 4'd3}, "R3");
      expect_look(32'h1000 + 15 * 7, {1'b1, 4'(15 ^ 5), 4'd15}, "R3");

      // R4/R5: after filling 0..15 in order, LRU is entry 0; hit 3 and 15 moved them front
      phase = "R4";
      expect_look(32'hDEAD, 9'h000, "R4");
      phase = "R5";
      expect_look(32'h1000, {1'b1, 4'd5, 4'd0}, "R5");
      expect_look(32'hBEEF, 9'h001, "R5");
      expect_look(32'hBEEF, 9'h001, "R5");

      // R6: duplicate tags
      phase = "R6";
      wr(9, 32'h7777, 4'hA); tick();
      wr(3, 32'h7777, 4'h6); tick();
      expect_look(32'h7777, {1'b1, 4'h6, 4'd3}, "R6");

      // R7: clear
      phase = "R7";
      clr = 1; tick();
      expect_look(32'h7777, 9'h001, "R7");
      wr(12, 32'h7777, 4'h2); tick();
      expect_look(32'h7777, {1'b1, 4'h2, 4'd12}, "R7");

      // R8: coincident operations
      phase = "R8";
      wr(12, 32'h4444, 4'h9); lk(32'h7777); tick();
      tick();
      total++;
      if (res_word !== {1'b1, 4'h2, 4'd12}) begin
         bad++;
         $display("FAIL R8 lookup saw new write act=%h exp=%h", res_word, {1'b1, 4'h2, 4'd12});
      end
      clr = 1; lk(32'h4444); tick();
      tick();
      expect_look(32'h4444, 9'h001, "R8");
      clr = 1; wr(5, 32'h5555, 4'h1); tick();
      expect_look(32'h5555, {1'b1, 4'h1, 4'd5}, "R8");
      wr(7, 32'h6666, 4'h3); lk(32'h5555); tick();
      expect_look(32'h6666, {1'b1, 4'h3, 4'd7}, "R8");

      // pseudo-random mix over a small key set
      phase = "R8";
      seed = 11;
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom(seed + n) ;
         if (r[3:0] < 6) wr(r[7:4], 32'(r[9:8]) + 32'h20, r[13:10]);
         if (r[15:14] != 0) lk(32'(r[17:16]) + 32'h20);
         if (r[23:18] == 0) clr = 1;
         tick();
      end
      tick();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule